// File: doc/BRIEF.md
# Two-Plane Half-Adder Cell Mesh

This block is a small rectangular mesh of identical bit-level cells meant for cellular-automaton style stepping. Each cell adds its two one-bit inputs as a half adder. The sum is kept in an A-plane register. The inverted carry, which is the NAND of the inputs, is kept in a B-plane register. The two inputs of a cell come from its four orthogonal neighbours only. The A input always reads a neighbour's A register and the B input always reads a neighbour's B register, so the two planes never exchange values. A source outside the mesh reads a constant 0.

Software, or a loader, writes a 5-bit word for one cell at a time. The word picks the neighbour that feeds each input, and it picks whether the observed A value of that cell is the stored sum or the live sum of its current inputs. The whole mesh advances by one generation on each clock edge while the step enable is high and holds while it is low. The A and B values of every cell are visible as flat vectors, with cell (row, col) at bit row*COLS+col.

Top module: `cell_mesh_fabric`

## Requirements
- R1: After reset every A and B register is 0, every configuration word is 0, and both observed vectors read all zeros.
- R2: A configuration write stores the 5-bit word for cell (cfg_row, cfg_col) at the clock edge. Bits [1:0] select the A source and bits [3:2] select the B source, coded 0 = row-1, 1 = row+1, 2 = col+1, 3 = col-1. Bit 4 set makes the observed A value the live sum. The new word is in use from that edge onward.
- R3: A write whose row is at least ROWS or whose column is at least COLS changes no cell configuration.
- R4: On an edge with step_en high, each A register loads the XOR of the cell's selected A-plane input and its selected B-plane input.
- R5: On an edge with step_en high, each B register loads the NAND of the same two inputs.
- R6: While step_en is low, no A or B register changes.
- R7: A cell's A input is taken only from a neighbour's A register, and its B input only from a neighbour's B register.
- R8: A selector that points outside the mesh supplies 0 to that input.
- R9: With bit 4 clear, a_obs shows the A register. With bit 4 set, it shows the XOR of the cell's present inputs.
- R10: A configuration write does not alter any A or B register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Advance all cells by one generation on this edge |
| cfg_we | input | 1 | Write one cell configuration word |
| cfg_row | input | RW | Row of the cell being written |
| cfg_col | input | CW | Column of the cell being written |
| cfg_word | input | 5 | Configuration word {live_sum, b_src[1:0], a_src[1:0]} |
| a_obs | output | ROWS*COLS | Observed A value of every cell |
| b_obs | output | ROWS*COLS | B register of every cell |

## Verification
The hardest state to reach is a mesh that has mixed selector patterns and edge cells reading off-array sources, while the step pattern is irregular and writes land in the middle of a run. No directed sequence covers that space. The bench therefore fills every configuration word at random, including out-of-range addresses, and interleaves steps and writes from a seeded generator. A bench model of both planes predicts every observed bit after every edge. Directed steps pin down the reset state, the first NAND generation, live-sum observation, and off-array reads.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  typedef struct packed {
    logic live_sum;
    dir_e src_b;
    dir_e src_a;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/mesh_rst_sync.sv
module mesh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/mesh_cfg_bank.sv
module mesh_cfg_bank #(
  parameter int ROWS = 3,
  parameter int COLS = 5,
  parameter int RW   = 2,
  parameter int CW   = 3
) (
  input  logic                                   clk,
  input  logic                                   srst_n,
  input  logic                                   we,
  input  logic [RW-1:0]                          row,
  input  logic [CW-1:0]                          col,
  input  mesh_pkg::cell_cfg_t                    word,
  output mesh_pkg::cell_cfg_t [ROWS*COLS-1:0]    cfg_q
);
  localparam int N = ROWS * COLS;
  localparam logic [RW-1:0] ROW_LIM = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LIM = CW'(COLS - 1);

  mesh_pkg::cell_cfg_t [N-1:0] cfg_d;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam logic [RW-1:0] MY_R = RW'(r);
      localparam logic [CW-1:0] MY_C = CW'(c);
      always_comb begin
        if (we && row == MY_R && col == MY_C) cfg_d[r*COLS+c] = word;
        else                                  cfg_d[r*COLS+c] = cfg_q[r*COLS+c];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  // R3: an address outside the mesh leaves every word untouched
  assert_oob_ignored_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (we && (row > ROW_LIM || col > COL_LIM)) |=> $stable(cfg_q));
endmodule

// File: rtl/mesh_cell.sv
module mesh_cell (
  input  logic clk,
  input  logic srst_n,
  input  logic step_en,
  input  logic a_in,
  input  logic b_in,
  input  logic live_sum,
  output logic a_q,
  output logic b_q,
  output logic a_obs
);
  logic sum_c, nand_c, a_d, b_d;

  always_comb begin
    sum_c  = a_in ^ b_in;
    nand_c = ~(a_in & b_in);
    a_d    = step_en ? sum_c  : a_q;
    b_d    = step_en ? nand_c : b_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_obs = live_sum ? sum_c : a_q;

  assert_sum_load_R4: assert property (@(posedge clk) disable iff (!srst_n)
    step_en |=> (a_q == ($past(a_in) ^ $past(b_in))));
  assert_nand_load_R5: assert property (@(posedge clk) disable iff (!srst_n)
    step_en |=> (b_q == !($past(a_in) && $past(b_in))));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !step_en |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/cell_mesh_fabric.sv
module cell_mesh_fabric #(
  parameter  int ROWS = 3,
  parameter  int COLS = 5,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int N    = ROWS * COLS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_row,
  input  logic [CW-1:0] cfg_col,
  input  logic [4:0]    cfg_word,
  output logic [N-1:0]  a_obs,
  output logic [N-1:0]  b_obs
);
  import mesh_pkg::*;

  logic               srst_n;
  cell_cfg_t [N-1:0]  cfg_q;
  logic [N-1:0]       a_q, b_q, a_in, b_in;

  mesh_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  mesh_cfg_bank #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_cfg (
    .clk(clk), .srst_n(srst_n), .we(cfg_we), .row(cfg_row), .col(cfg_col),
    .word(cell_cfg_t'(cfg_word)), .cfg_q(cfg_q)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I = r * COLS + c;
      logic [3:0] nb_a, nb_b;

      // neighbour candidates per plane, index = direction code
      if (r > 0) begin : g_n
        assign nb_a[DIR_N] = a_q[I-COLS];
        assign nb_b[DIR_N] = b_q[I-COLS];
      end else begin : g_n0
        assign nb_a[DIR_N] = 1'b0;
        assign nb_b[DIR_N] = 1'b0;
      end
      if (r < ROWS - 1) begin : g_s
        assign nb_a[DIR_S] = a_q[I+COLS];
        assign nb_b[DIR_S] = b_q[I+COLS];
      end else begin : g_s0
        assign nb_a[DIR_S] = 1'b0;
        assign nb_b[DIR_S] = 1'b0;
      end
      if (c < COLS - 1) begin : g_e
        assign nb_a[DIR_E] = a_q[I+1];
        assign nb_b[DIR_E] = b_q[I+1];
      end else begin : g_e0
        assign nb_a[DIR_E] = 1'b0;
        assign nb_b[DIR_E] = 1'b0;
      end
      if (c > 0) begin : g_w
        assign nb_a[DIR_W] = a_q[I-1];
        assign nb_b[DIR_W] = b_q[I-1];
      end else begin : g_w0
        assign nb_a[DIR_W] = 1'b0;
        assign nb_b[DIR_W] = 1'b0;
      end

      assign a_in[I] = nb_a[cfg_q[I].src_a];
      assign b_in[I] = nb_b[cfg_q[I].src_b];

      mesh_cell u_cell (
        .clk(clk), .srst_n(srst_n), .step_en(step_en),
        .a_in(a_in[I]), .b_in(b_in[I]), .live_sum(cfg_q[I].live_sum),
        .a_q(a_q[I]), .b_q(b_q[I]), .a_obs(a_obs[I])
      );

      if (r == 0) begin : g_top_edge
        // R8: both inputs off the mesh -> sum 0, nand 1
        assert_offmesh_zero_R8: assert property (@(posedge clk) disable iff (!srst_n)
          (step_en && cfg_q[I].src_a == DIR_N && cfg_q[I].src_b == DIR_N)
          |=> (a_q[I] == 1'b0 && b_q[I] == 1'b1));
      end
    end
  end

  assign b_obs = b_q;

  // R10: a write without a step leaves both planes as they were
  assert_write_keeps_state_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_we && !step_en) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/test_cell_mesh_fabric.sv
module test_cell_mesh_fabric;
  localparam int ROWS = 3;
  localparam int COLS = 5;
  localparam int N    = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n, step_en, cfg_we;
  logic [1:0] cfg_row;
  logic [2:0] cfg_col;
  logic [4:0] cfg_word;
  logic [N-1:0] a_obs, b_obs;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [N-1:0] ma, mb;
  logic [4:0]   mcfg [N];

  always #5 clk = ~clk;

  cell_mesh_fabric #(.ROWS(ROWS), .COLS(COLS)) i_cell_mesh_fabric (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .cfg_we(cfg_we),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_word(cfg_word),
    .a_obs(a_obs), .b_obs(b_obs)
  );

  function automatic logic pick(input logic [N-1:0] pl, input int r, input int c,
                                input logic [1:0] sel);
    case (sel)
      2'd0:    return (r > 0)        ? pl[(r-1)*COLS+c] : 1'b0;
      2'd1:    return (r < ROWS - 1) ? pl[(r+1)*COLS+c] : 1'b0;
      2'd2:    return (c < COLS - 1) ? pl[r*COLS+c+1]   : 1'b0;
      default: return (c > 0)        ? pl[r*COLS+c-1]   : 1'b0;
    endcase
  endfunction

  function automatic logic in_a(input int i);
    return pick(ma, i / COLS, i % COLS, mcfg[i][1:0]);
  endfunction
  function automatic logic in_b(input int i);
    return pick(mb, i / COLS, i % COLS, mcfg[i][3:2]);
  endfunction

  function automatic logic [N-1:0] exp_a_obs();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = mcfg[i][4] ? (in_a(i) ^ in_b(i)) : ma[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model after posedge, return at next negedge
  task automatic cyc(input logic st, input logic we, input logic [1:0] r,
                     input logic [2:0] c, input logic [4:0] w);
    logic [N-1:0] na, nb;
    step_en = st; cfg_we = we; cfg_row = r; cfg_col = c; cfg_word = w;
    for (int i = 0; i < N; i++) begin
      na[i] = in_a(i) ^ in_b(i);
      nb[i] = ~(in_a(i) & in_b(i));
    end
    @(posedge clk);
    #1;
    if (st) begin ma = na; mb = nb; end
    if (we && r < ROWS && c < COLS) mcfg[r*COLS+c] = w;
    @(negedge clk);
    step_en = 0; cfg_we = 0;
  endtask

  initial begin
    #2ms;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 0; step_en = 0; cfg_we = 0; cfg_row = 0; cfg_col = 0; cfg_word = 0;
    ma = '0; mb = '0;
    for (int i = 0; i < N; i++) mcfg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    chk("R1 a_obs after reset", a_obs, '0);
    chk("R1 b_obs after reset", b_obs, '0);

    // all sources north, all zero: sum 0, nand 1 everywhere
    cyc(1, 0, 0, 0, 0);
    chk("R5 first generation B", b_obs, {N{1'b1}});
    chk("R4 first generation A", a_obs, '0);

    cyc(0, 0, 0, 0, 0);
    chk("R6 hold A", a_obs, exp_a_obs());
    chk("R6 hold B", b_obs, {N{1'b1}});

    // cell (1,2): live sum, A from west, B from east -> 0 ^ 1 = 1 at once
    cyc(0, 1, 2'd1, 3'd2, 5'b1_10_11);
    chk("R9 live sum observed", a_obs, exp_a_obs());
    chk("R2 word takes effect", a_obs[1*COLS+2], 1'b1);
    chk("R10 write keeps B", b_obs, mb);

    // out-of-range row and column writes
    cyc(0, 1, 2'd3, 3'd1, 5'b1_01_01);
    cyc(0, 1, 2'd0, 3'd6, 5'b1_01_01);
    chk("R3 oob write ignored", a_obs, exp_a_obs());
    cyc(1, 0, 0, 0, 0);
    chk("R3 oob after step A", a_obs, exp_a_obs());

    // corner cell (0,0): A north, B west -> both off-mesh
    cyc(0, 1, 2'd0, 3'd0, 5'b0_11_00);
    cyc(1, 0, 0, 0, 0);
    chk("R8 off-mesh A", a_obs[0], 1'b0);
    chk("R8 off-mesh B", b_obs[0], 1'b1);

    // interior cell (1,1): A from east, B from south; planes separate
    cyc(0, 1, 2'd1, 3'd1, 5'b0_01_10);
    cyc(1, 0, 0, 0, 0);
    chk("R7 plane routing A", a_obs, exp_a_obs());
    chk("R7 plane routing B", b_obs, mb);

    // seeded random mix
    for (int k = 0; k < 400; k++) begin
      logic st, we;
      st = ($urandom % 3) != 0;
      we = ($urandom % 2) != 0;
      cyc(st, we, 2'($urandom % 4), 3'($urandom % 8), 5'($urandom));
      chk("R4 R9 random A", a_obs, exp_a_obs());
      chk("R5 R7 random B", b_obs, mb);
    end

    // reset again mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    ma = '0; mb = '0;
    for (int i = 0; i < N; i++) mcfg[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 re-reset A", a_obs, '0);
    chk("R1 re-reset B", b_obs, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule